// File: doc/BRIEF.md
# Multi-Packet Endpoint Transfer Sequencer

This block carries one software-defined buffer in RAM across a USB device endpoint as a chain of packets, so software acts only at the start and at the end of the transfer. Software gives the buffer start address, the total byte count and the endpoint's maximum packet size, then pulses `start`. For each packet the block works out its length, streams bytes out of RAM to the transmitter (IN) or from the receiver into RAM (OUT), and moves on once the packet is accepted. It raises one completion flag when the whole buffer has been handled.

The neighbouring logic does the token decoding and handshakes. It tells the sequencer when an IN or OUT token for this endpoint arrives, when an IN packet was acknowledged or refused, and when a received OUT packet ended cleanly or was corrupt. A refused or corrupt packet is sent again from the same place. RAM data that is missing while the transmitter is waiting for it raises a sticky error flag and aborts that packet. An OUT packet shorter than the maximum packet size ends the transfer early, and the byte count shows how much actually arrived.

Top module: `mpkt_seq`

## Requirements
- R1: `start` is accepted only while the block is idle, `cfgEnable` is 1 and `cfgMaxPkt` is nonzero. Accepting it sets `busy` and clears `xferCount` on the next edge. In every other case `start` changes nothing, including a `start` that arrives during a transfer.
- R2: While a transfer is waiting for a token, `pktLen` equals the smaller of the remaining byte count and the maximum packet size.
- R3: A packet's bytes use consecutive RAM addresses, beginning at the current buffer address.
  - For IN, `txData` carries `ramRdata`, `txValid` follows `ramGnt`, and `txLast` marks the packet's final byte.
  - For OUT, each byte in the packet writes `rxData` with `ramReq` and `ramWe` both high.
- R4: The transfer advances on an acknowledged IN packet or a cleanly ended OUT packet. The buffer address and `xferCount` then move forward by the number of bytes moved, and the remaining count drops by the same amount.
- R5: A refused IN packet (`hsNak`) or a corrupt OUT packet (`rxBad`) leaves the address, remaining count and `xferCount` unchanged. The next token repeats the same packet.
- R6: During an IN packet with bytes still to send, `txReady` high with `ramGnt` low is an underflow. It sets `errFlag` and aborts the packet, which is then retried in full. The transfer stays busy.
- R7: `doneIrq` rises once per transfer, on the edge that completes its last packet. `busy` falls on that same edge, and `doneIrq` stays low while packets remain.
- R8: For IN with `cfgZlpEn`=1, a total that is an exact multiple of the packet size is followed by one zero-length packet before completion. With `cfgZlpEn`=0 the transfer completes after the last full packet. A total of zero always sends one zero-length packet.
- R9: A clean OUT packet shorter than the maximum packet size ends the transfer. `xferCount` then holds the bytes actually received.
- R10: `doneIrq` and `errFlag` stay set until `clrDone` or `clrErr` is pulsed. A set and a clear on the same edge leave the flag set.
- R11: An IN token during an OUT transfer, an OUT token during an IN transfer, and any token while idle are ignored. While idle, `ramReq` and `txValid` stay low.
- R12: OUT bytes that arrive after the packet length has been reached produce no RAM write and are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Endpoint configured and usable |
| cfgDirIn | input | 1 | Transfer direction: 1 = IN (device to host), 0 = OUT |
| cfgZlpEn | input | 1 | Send a closing zero-length IN packet after an exact multiple |
| cfgMaxPkt | input | PKT_W | Endpoint maximum packet size in bytes |
| start | input | 1 | Begin a transfer with the values below |
| startAddr | input | ADDR_W | Buffer start address |
| totalBytes | input | CNT_W | Buffer length in bytes |
| clrDone | input | 1 | Clear pulse for the completion flag |
| clrErr | input | 1 | Clear pulse for the underflow flag |
| tokenIn | input | 1 | IN token received for this endpoint |
| tokenOut | input | 1 | OUT token received for this endpoint |
| hsAck | input | 1 | Host acknowledged the IN packet |
| hsNak | input | 1 | IN packet was not accepted; resend |
| txReady | input | 1 | Transmitter takes a byte this cycle |
| txValid | output | 1 | Transmit byte is valid |
| txData | output | DATA_W | Transmit byte |
| txLast | output | 1 | Current transmit byte is the packet's last |
| rxValid | input | 1 | Received byte valid |
| rxData | input | DATA_W | Received byte |
| rxEnd | input | 1 | Received packet ended cleanly |
| rxBad | input | 1 | Received packet was corrupt; discard |
| ramReq | output | 1 | RAM access request |
| ramWe | output | 1 | RAM access is a write |
| ramAddr | output | ADDR_W | RAM byte address |
| ramWdata | output | DATA_W | RAM write data |
| ramGnt | input | 1 | RAM read granted, data valid this cycle |
| ramRdata | input | DATA_W | RAM read data |
| busy | output | 1 | Transfer in progress |
| pktLen | output | PKT_W | Length of the current packet |
| xferCount | output | CNT_W | Bytes moved so far in this transfer |
| doneIrq | output | 1 | Sticky completion flag |
| errFlag | output | 1 | Sticky RAM underflow flag |

## Verification
The outputs fall into two timing groups.
- Same cycle: the RAM strobes, address and write data, and the transmit valid, data and last-byte outputs, are combinational from the current state and inputs. They are due in the cycle the stimulus is applied.
- One edge later: `busy`, `pktLen`, `xferCount`, `doneIrq` and `errFlag` come from registers. They change on the first rising edge after the input that causes them.

The bench follows this split. It drives inputs just after a falling edge and checks the combinational outputs 1 ns later. It checks the registered outputs at the next falling edge, half a cycle after the edge that updates them. The expected address, length, count and completion of every packet come from a bench model of the remaining bytes.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_IN_DATA,
    ST_IN_HS,
    ST_OUT_DATA
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldStart;   // capture a new transfer
    logic byteClr;   // restart the byte index of a packet
    logic byteStep;  // one byte moved
    logic advance;   // commit the packet just moved
  } dpCmd_t;

endpackage

// File: rtl/mpkt_dp.sv
module mpkt_dp
  import mpkt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14,
  parameter int PKT_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic [PKT_W-1:0]  cfgMaxPkt,
  input  logic              cfgDirIn,
  input  logic              cfgZlpEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [PKT_W-1:0]  pktLen,
  output logic [CNT_W-1:0]  xferCount,
  output logic              dirIn,
  output logic              pktEmpty,
  output logic              lastByte,
  output logic              idxBelowLen,
  output logic              doneIfAdv
);

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  xferCnt;
  logic [PKT_W-1:0]  maxPktQ;
  logic [PKT_W-1:0]  byteIdx;
  logic              zlpQ;

  logic [CNT_W-1:0]  maxExt;
  logic [CNT_W-1:0]  idxExt;
  logic [CNT_W-1:0]  pktLenW;
  logic [CNT_W-1:0]  remAfter;
  logic              shortPkt;

  always_comb begin
    maxExt      = CNT_W'(maxPktQ);
    idxExt      = CNT_W'(byteIdx);
    pktLenW     = (remain < maxExt) ? remain : maxExt;
    pktLen      = pktLenW[PKT_W-1:0];
    pktEmpty    = (pktLenW == '0);
    lastByte    = ((idxExt + CNT_W'(1)) == pktLenW);
    idxBelowLen = (idxExt < pktLenW);
    remAfter    = remain - idxExt;
    shortPkt    = (byteIdx < maxPktQ);
    // a short packet ends the transfer; a full one ends it when the buffer is
    // empty unless a closing zero-length IN packet is still owed
    doneIfAdv   = shortPkt || ((remAfter == '0) && !(dirIn && zlpQ));
    ramAddr     = curAddr + ADDR_W'(byteIdx);
    xferCount   = xferCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
      xferCnt <= '0;
      maxPktQ <= '0;
      dirIn   <= 1'b0;
      zlpQ    <= 1'b0;
    end else if (cmd.ldStart) begin
      curAddr <= startAddr;
      remain  <= totalBytes;
      xferCnt <= '0;
      maxPktQ <= cfgMaxPkt;
      dirIn   <= cfgDirIn;
      zlpQ    <= cfgZlpEn;
    end else if (cmd.advance) begin
      curAddr <= curAddr + ADDR_W'(byteIdx);
      remain  <= remain - idxExt;
      xferCnt <= xferCnt + idxExt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (cmd.byteClr || cmd.advance) begin
      byteIdx <= '0;
    end else if (cmd.byteStep) begin
      byteIdx <= byteIdx + PKT_W'(1);
    end
  end

endmodule

// File: rtl/mpkt_ctrl.sv
module mpkt_ctrl
  import mpkt_pkg::*;
#(
  parameter int PKT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [PKT_W-1:0] cfgMaxPkt,
  input  logic             start,
  input  logic             clrDone,
  input  logic             clrErr,
  input  logic             tokenIn,
  input  logic             tokenOut,
  input  logic             hsAck,
  input  logic             hsNak,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic             rxEnd,
  input  logic             rxBad,
  input  logic             ramGnt,
  input  logic             dirIn,
  input  logic             pktEmpty,
  input  logic             lastByte,
  input  logic             idxBelowLen,
  input  logic             doneIfAdv,
  output dpCmd_t           cmd,
  output logic             txValid,
  output logic             txLast,
  output logic             ramReq,
  output logic             ramWe,
  output logic             busy,
  output logic             doneIrq,
  output logic             errFlag
);

  seqState_t state, nextState;
  logic      setDone;
  logic      setErr;

  always_comb begin
    nextState = state;
    cmd       = '0;
    setDone   = 1'b0;
    setErr    = 1'b0;
    ramReq    = 1'b0;
    ramWe     = 1'b0;
    txValid   = 1'b0;
    txLast    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && cfgEnable && (cfgMaxPkt != '0)) begin
          cmd.ldStart = 1'b1;
          nextState   = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (tokenIn && dirIn) begin
          cmd.byteClr = 1'b1;
          nextState   = ST_IN_DATA;
        end else if (tokenOut && !dirIn) begin
          cmd.byteClr = 1'b1;
          nextState   = ST_OUT_DATA;
        end
      end
      ST_IN_DATA: begin
        if (pktEmpty) begin
          nextState = ST_IN_HS;
        end else begin
          ramReq  = 1'b1;
          txValid = ramGnt;
          txLast  = lastByte;
          if (txReady) begin
            if (ramGnt) begin
              cmd.byteStep = 1'b1;
              if (lastByte) nextState = ST_IN_HS;
            end else begin
              setErr    = 1'b1;
              nextState = ST_ARMED;
            end
          end
        end
      end
      ST_IN_HS: begin
        if (hsAck) begin
          cmd.advance = 1'b1;
          if (doneIfAdv) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else begin
            nextState = ST_ARMED;
          end
        end else if (hsNak) begin
          nextState = ST_ARMED;
        end
      end
      ST_OUT_DATA: begin
        if (rxBad) begin
          nextState = ST_ARMED;
        end else if (rxEnd) begin
          cmd.advance = 1'b1;
          if (doneIfAdv) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else begin
            nextState = ST_ARMED;
          end
        end else if (rxValid && idxBelowLen) begin
          ramReq       = 1'b1;
          ramWe        = 1'b1;
          cmd.byteStep = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneIrq <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= nextState;
      doneIrq <= setDone | (doneIrq & ~clrDone);
      errFlag <= setErr | (errFlag & ~clrErr);
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mpkt_seq.sv
module mpkt_seq
  import mpkt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14,
  parameter int PKT_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgDirIn,
  input  logic              cfgZlpEn,
  input  logic [PKT_W-1:0]  cfgMaxPkt,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic              clrDone,
  input  logic              clrErr,
  input  logic              tokenIn,
  input  logic              tokenOut,
  input  logic              hsAck,
  input  logic              hsNak,
  input  logic              txReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              txLast,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxEnd,
  input  logic              rxBad,
  output logic              ramReq,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic              ramGnt,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              busy,
  output logic [PKT_W-1:0]  pktLen,
  output logic [CNT_W-1:0]  xferCount,
  output logic              doneIrq,
  output logic              errFlag
);

  dpCmd_t cmd;
  logic   dirIn;
  logic   pktEmpty;
  logic   lastByte;
  logic   idxBelowLen;
  logic   doneIfAdv;

  mpkt_ctrl #(.PKT_W(PKT_W)) ctrlI (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaxPkt(cfgMaxPkt),
    .start(start), .clrDone(clrDone), .clrErr(clrErr),
    .tokenIn(tokenIn), .tokenOut(tokenOut), .hsAck(hsAck), .hsNak(hsNak),
    .txReady(txReady), .rxValid(rxValid), .rxEnd(rxEnd), .rxBad(rxBad),
    .ramGnt(ramGnt), .dirIn(dirIn), .pktEmpty(pktEmpty), .lastByte(lastByte),
    .idxBelowLen(idxBelowLen), .doneIfAdv(doneIfAdv), .cmd(cmd),
    .txValid(txValid), .txLast(txLast), .ramReq(ramReq), .ramWe(ramWe),
    .busy(busy), .doneIrq(doneIrq), .errFlag(errFlag)
  );

  mpkt_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PKT_W(PKT_W)) dpI (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startAddr(startAddr),
    .totalBytes(totalBytes), .cfgMaxPkt(cfgMaxPkt), .cfgDirIn(cfgDirIn),
    .cfgZlpEn(cfgZlpEn), .ramAddr(ramAddr), .pktLen(pktLen),
    .xferCount(xferCount), .dirIn(dirIn), .pktEmpty(pktEmpty),
    .lastByte(lastByte), .idxBelowLen(idxBelowLen), .doneIfAdv(doneIfAdv)
  );

  assign txData   = ramRdata;
  assign ramWdata = rxData;

endmodule

// File: rtl/mpkt_seq_chk.sv
module mpkt_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic              txLast,
  input logic              ramReq,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              rxValid,
  input logic              errFlag,
  input logic              clrErr,
  input logic              doneIrq,
  input logic              busy,
  input logic [CNT_W-1:0]  xferCount
);

  // R3: after a byte leaves mid-packet, the next read targets the next address
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !txLast) |=>
      (ramReq && !ramWe && (ramAddr == $past(ramAddr) + ADDR_W'(1))));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrErr) |=> errFlag);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> !busy);

  assert_count_monotonic_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (xferCount >= $past(xferCount)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ramReq && !txValid));

  assert_write_needs_rx_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ramReq && ramWe) |-> rxValid);

endmodule

bind mpkt_seq mpkt_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chkI (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txLast(txLast), .ramReq(ramReq), .ramWe(ramWe), .ramAddr(ramAddr),
  .rxValid(rxValid), .errFlag(errFlag), .clrErr(clrErr), .doneIrq(doneIrq),
  .busy(busy), .xferCount(xferCount)
);

// File: tb/mpkt_seq_tb_top.sv
module mpkt_seq_tb_top;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 14;
  localparam int PKT_W  = 11;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              cfgEnable = 1'b0, cfgDirIn = 1'b0, cfgZlpEn = 1'b0;
  logic [PKT_W-1:0]  cfgMaxPkt = '0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0]  totalBytes = '0;
  logic              clrDone = 1'b0, clrErr = 1'b0;
  logic              tokenIn = 1'b0, tokenOut = 1'b0, hsAck = 1'b0, hsNak = 1'b0;
  logic              txReady = 1'b0;
  logic              txValid, txLast;
  logic [DATA_W-1:0] txData;
  logic              rxValid = 1'b0, rxEnd = 1'b0, rxBad = 1'b0;
  logic [DATA_W-1:0] rxData = '0;
  logic              ramReq, ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;
  logic              ramGnt = 1'b0;
  logic [DATA_W-1:0] ramRdata;
  logic              busy, doneIrq, errFlag;
  logic [PKT_W-1:0]  pktLen;
  logic [CNT_W-1:0]  xferCount;

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] expData(input int ad);
    return 8'(ad) ^ 8'hA5;
  endfunction

  // RAM model: read data is a function of the address
  assign ramRdata = expData(int'(ramAddr));

  mpkt_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PKT_W(PKT_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDirIn(cfgDirIn),
    .cfgZlpEn(cfgZlpEn), .cfgMaxPkt(cfgMaxPkt), .start(start),
    .startAddr(startAddr), .totalBytes(totalBytes), .clrDone(clrDone),
    .clrErr(clrErr), .tokenIn(tokenIn), .tokenOut(tokenOut), .hsAck(hsAck),
    .hsNak(hsNak), .txReady(txReady), .txValid(txValid), .txData(txData),
    .txLast(txLast), .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd),
    .rxBad(rxBad), .ramReq(ramReq), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramGnt(ramGnt), .ramRdata(ramRdata), .busy(busy),
    .pktLen(pktLen), .xferCount(xferCount), .doneIrq(doneIrq), .errFlag(errFlag)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearDone();
    clrDone = 1'b1;
    tick();
    clrDone = 1'b0;
    chk("R10", "completion flag cleared", doneIrq, 0);
  endtask

  task automatic runIn(input int addr, input int total, input int maxp, input bit zlp,
                       input int ufPct, input int nakPct, input bit poke, input bit clrAtEnd);
    int  rem, a, cnt, len, i, r;
    bit  finished, aborted, uf, stepNow;
    rem = total; a = addr; cnt = 0; finished = 1'b0;
    cfgEnable = 1'b1; cfgDirIn = 1'b1; cfgZlpEn = zlp;
    cfgMaxPkt = PKT_W'(maxp); startAddr = ADDR_W'(addr); totalBytes = CNT_W'(total);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R1", "busy after start", busy, 1);
    chk("R1", "count cleared at start", xferCount, 0);
    if (poke) begin
      totalBytes = CNT_W'(total + 40);
      startAddr  = ADDR_W'(addr + 100);
      start = 1'b1; tokenOut = 1'b1;
      #1;
      chk("R11", "OUT token on IN transfer makes no access", ramReq, 0);
      tick();
      start = 1'b0; tokenOut = 1'b0;
      chk("R1", "restart during transfer ignored", xferCount, 0);
      chk("R11", "still waiting after wrong token", busy, 1);
    end
    while (!finished) begin
      len = (rem < maxp) ? rem : maxp;
      chk("R2", "IN packet length", pktLen, len);
      tokenIn = 1'b1;
      tick();
      tokenIn = 1'b0;
      aborted = 1'b0;
      if (len == 0) begin
        txReady = 1'b1; ramGnt = 1'b1;
        #1;
        chk("R8", "zero-length packet sends no byte", txValid, 0);
        tick();
        txReady = 1'b0; ramGnt = 1'b0;
      end else begin
        i = 0;
        while (i < len) begin
          r = int'($urandom_range(99));
          if (r < 8) begin
            txReady = 1'b0; ramGnt = r[0];
          end else if (r < 8 + ufPct) begin
            txReady = 1'b1; ramGnt = 1'b0;
          end else begin
            txReady = 1'b1; ramGnt = 1'b1;
          end
          #1;
          chk("R3", "IN read address", ramAddr, (a + i) & 16'hFFFF);
          uf      = txReady && !ramGnt;
          stepNow = txReady && ramGnt;
          if (stepNow) begin
            chk("R3", "IN byte value", txData, expData(a + i));
            chk("R3", "IN last-byte marker", txLast, (i == len - 1));
          end
          tick();
          txReady = 1'b0; ramGnt = 1'b0;
          if (uf) begin
            chk("R6", "underflow flag", errFlag, 1);
            chk("R6", "busy after underflow", busy, 1);
            chk("R6", "count held after underflow", xferCount, cnt);
            clrErr = 1'b1;
            tick();
            clrErr = 1'b0;
            chk("R10", "underflow flag cleared", errFlag, 0);
            aborted = 1'b1;
            break;
          end
          if (stepNow) i++;
        end
      end
      if (aborted) continue;
      if (int'($urandom_range(99)) < nakPct) begin
        hsNak = 1'b1;
        tick();
        hsNak = 1'b0;
        chk("R5", "count held after NAK", xferCount, cnt);
        chk("R5", "busy after NAK", busy, 1);
        continue;
      end
      rem -= len; a += len; cnt += len;
      finished = (len < maxp) || (rem == 0 && !zlp);
      hsAck = 1'b1;
      if (finished && clrAtEnd) clrDone = 1'b1;
      tick();
      hsAck = 1'b0; clrDone = 1'b0;
      chk("R4", "count after ACK", xferCount, cnt);
      if (rem == 0 && len == maxp)
        chk("R8", "completion after final full packet", doneIrq, !zlp);
      else
        chk("R7", "completion flag after ACK", doneIrq, finished);
      chk("R7", "busy after ACK", busy, !finished);
      if (finished && clrAtEnd) chk("R10", "set wins over clear", doneIrq, 1);
    end
    clearDone();
  endtask

  task automatic runOut(input int addr, input int total, input int maxp,
                        input int shortPct, input int badPct, input bit extra);
    int  rem, a, cnt, len, n, got;
    bit  finished, bad;
    rem = total; a = addr; cnt = 0; finished = 1'b0;
    cfgEnable = 1'b1; cfgDirIn = 1'b0; cfgZlpEn = 1'b1;
    cfgMaxPkt = PKT_W'(maxp); startAddr = ADDR_W'(addr); totalBytes = CNT_W'(total);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R1", "busy after OUT start", busy, 1);
    tokenIn = 1'b1;
    tick();
    tokenIn = 1'b0;
    rxValid = 1'b1;
    #1;
    chk("R11", "IN token on OUT transfer ignored", ramReq, 0);
    rxValid = 1'b0;
    while (!finished) begin
      len = (rem < maxp) ? rem : maxp;
      chk("R2", "OUT packet length", pktLen, len);
      tokenOut = 1'b1;
      tick();
      tokenOut = 1'b0;
      n = len;
      if (len > 0 && int'($urandom_range(99)) < shortPct) n = int'($urandom_range(len - 1));
      if (extra && n == len) n = len + 2;
      bad = int'($urandom_range(99)) < badPct;
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(3) == 0) tick();
        rxValid = 1'b1;
        rxData  = 8'($urandom);
        #1;
        if (k < len) begin
          chk("R3", "OUT write strobe", ramReq && ramWe, 1);
          chk("R3", "OUT write address", ramAddr, (a + k) & 16'hFFFF);
          chk("R3", "OUT write data", ramWdata, rxData);
        end else begin
          chk("R12", "byte past packet end not written", ramReq, 0);
        end
        tick();
        rxValid = 1'b0;
      end
      if (bad) begin
        rxBad = 1'b1;
        tick();
        rxBad = 1'b0;
        chk("R5", "count held after bad packet", xferCount, cnt);
        continue;
      end
      got = (n < len) ? n : len;
      rem -= got; a += got; cnt += got;
      finished = (got < maxp) || (rem == 0);
      rxEnd = 1'b1;
      tick();
      rxEnd = 1'b0;
      if (n > len) chk("R12", "extra bytes not counted", xferCount, cnt);
      else if (got < len) chk("R9", "received count after short packet", xferCount, cnt);
      else chk("R4", "count after OUT packet", xferCount, cnt);
      if (got < len) chk("R9", "short packet completes", doneIrq, 1);
      else chk("R7", "completion flag after OUT packet", doneIrq, finished);
      chk("R7", "busy after OUT packet", busy, !finished);
    end
    clearDone();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int maxp, total, addr;
    void'($urandom(32'h1F2E));
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", busy, 0);
    chk("R10", "reset completion flag", doneIrq, 0);
    chk("R10", "reset error flag", errFlag, 0);
    chk("R4", "reset count", xferCount, 0);
    chk("R11", "reset ram request", ramReq, 0);
    rstN = 1'b1;
    tick();

    // R1: endpoint not configured, then zero packet size
    cfgEnable = 1'b0; cfgMaxPkt = PKT_W'(8); totalBytes = CNT_W'(10);
    start = 1'b1; tick(); start = 1'b0;
    chk("R1", "start ignored on disabled endpoint", busy, 0);
    cfgEnable = 1'b1; cfgMaxPkt = '0;
    start = 1'b1; tick(); start = 1'b0;
    chk("R1", "start ignored with zero packet size", busy, 0);

    // R11: tokens while idle
    tokenIn = 1'b1; txReady = 1'b1; ramGnt = 1'b1;
    tick();
    tokenIn = 1'b0;
    #1;
    chk("R11", "idle IN token gives no transmit", txValid, 0);
    chk("R11", "idle IN token gives no access", ramReq, 0);
    txReady = 1'b0; ramGnt = 1'b0;
    tick();

    runIn(16'h0100, 20, 8, 1'b0, 0, 0, 1'b1, 1'b0);
    runIn(16'h0200, 16, 8, 1'b1, 0, 0, 1'b0, 1'b0);
    runIn(16'h0300, 16, 8, 1'b0, 0, 0, 1'b0, 1'b1);
    runIn(16'h0400, 0, 8, 1'b0, 0, 0, 1'b0, 1'b0);
    runIn(16'h0500, 30, 8, 1'b0, 15, 30, 1'b0, 1'b0);
    runOut(16'h0600, 20, 8, 0, 0, 1'b1);
    runOut(16'h0700, 64, 16, 100, 0, 1'b0);
    runOut(16'h0800, 40, 8, 0, 40, 1'b0);

    for (int t = 0; t < 16; t++) begin
      maxp  = 1 + int'($urandom_range(63));
      total = int'($urandom_range(150));
      addr  = int'($urandom_range(16'hE000));
      if (t % 2 == 1)
        runIn(addr, total, maxp, 1'($urandom_range(1)), 5, 15, 1'b0, (t % 3) == 0);
      else
        runOut(addr, total, maxp, 20, 10, (t % 3) == 0);
    end

    summary();
    $finish;
  end

endmodule